// File: doc/BRIEF.md
# Deferred-Inclusion Receive Block Check

This block keeps a running 16-bit block check over a stream of received bytes. Each byte can be left out of the check after it has been seen. A byte that has just arrived is not folded in at once. It is held as a speculative result next to the committed check value. Software then has until the following byte completes to say whether the held byte belongs in the check. That lets control characters be recognised and stripped without corrupting the check.

The receive path pulses `byte_vld` with `byte_data` each time a byte completes. `keep` is sampled on that same strobe and decides the fate of the byte before it. `restart` opens a new block. `check_value` shows the committed accumulator. `block_good` reports that the check has come to zero over a block in which at least one byte was included. The receiver needs one trailing byte after the check bytes so that the last check byte is committed.

Top module: `deferred_check_rx`

## Requirements
- R1: While `rst_n` is low, and after its release with no further input, `check_value` is 0 and `block_good` is 0.
- R2: The check is a CRC over the polynomial x^16 + x^15 + x^2 + 1, starting from 0. Each byte is processed least significant bit first, which is the right-shifting form with mask 0xA001.
- R3: A byte is not folded into `check_value` on the strobe that delivers it. It stays pending until the next `byte_vld` strobe.
- R4: On a `byte_vld` strobe with `keep` = 1, the pending byte is folded into the committed value. `check_value` shows the result after that clock edge.
- R5: On a `byte_vld` strobe with `keep` = 0, the pending byte is dropped and `check_value` is unchanged. Later bytes are checked as if the dropped byte had never arrived.
- R6: `keep` has no effect in cycles without `byte_vld`.
- R7: `restart` clears the committed value, the pending byte and `block_good` at the next edge. If `byte_vld` is high in the same cycle, that byte becomes the first pending byte of the new block and the old pending byte is discarded.
- R8: `block_good` is 1 exactly when `check_value` is 0 and at least one byte has been included since the last reset or restart. It changes on the same edge as `check_value`.
- R9: Take a block whose check bytes (low byte first) are computed over the included bytes only. Send those check bytes with `keep` = 1, then send a trailing byte with `keep` = 1. `block_good` is then 1, even when control bytes in the block were dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Start a new block: clear both accumulators and the pending byte |
| byte_vld | input | 1 | One-cycle strobe marking a completed received byte |
| byte_data | input | 8 | Received byte, valid with `byte_vld` |
| keep | input | 1 | On a strobe: 1 includes the pending byte, 0 drops it |
| check_value | output | 16 | Committed check accumulator |
| block_good | output | 1 | Check is zero over at least one included byte |

## Verification
Two functions can fall in the same cycle: a restart and a byte strobe that judges the previous pending byte. The bench provokes this in the middle of a block, with a pending byte outstanding and `keep` held high. It then expects the old pending byte to be discarded, the value to clear, and the new byte to wait as the first pending byte. A behavioural model keeps a held byte and a committed integer, rather than two accumulators, and is compared with both outputs every cycle. Directed sequences cover dropped control bytes inside a block, idle cycles in which `keep` toggles, and a full block closed by its own check bytes and a trailer.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int unsigned CHK_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [CHK_W-1:0] CHK_MASK = 16'hA001;
endpackage

// File: rtl/rbc_crc_step.sv
module rbc_crc_step #(
  parameter int unsigned CHK_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [CHK_W-1:0] MASK = 16'hA001
) (
  input  logic [CHK_W-1:0]  seed,
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  result
);
  logic [CHK_W-1:0] stage [0:DATA_W];

  assign stage[0] = seed;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      logic fb;
      assign fb = stage[gi][0] ^ data[gi];
      assign stage[gi+1] = (stage[gi] >> 1) ^ (fb ? MASK : {CHK_W{1'b0}});
    end
  endgenerate

  assign result = stage[DATA_W];
endmodule

// File: rtl/rbc_defer_core.sv
module rbc_defer_core #(
  parameter int unsigned CHK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             byte_vld,
  input  logic             keep,
  input  logic [CHK_W-1:0] spec_calc,
  output logic [CHK_W-1:0] commit_nxt,
  output logic [CHK_W-1:0] commit_q,
  output logic             any_incl_q
);
  logic [CHK_W-1:0] spec_q, spec_nxt;
  logic             pend_q, pend_nxt;
  logic             any_incl_nxt;
  logic             include_now;
  logic             upd_en;

  assign upd_en      = restart | byte_vld;
  assign include_now = byte_vld & ~restart & pend_q & keep;

  always_comb begin
    commit_nxt   = commit_q;
    any_incl_nxt = any_incl_q;
    pend_nxt     = pend_q;
    spec_nxt     = spec_q;
    if (restart) begin
      commit_nxt   = {CHK_W{1'b0}};
      any_incl_nxt = 1'b0;
      pend_nxt     = byte_vld;
      spec_nxt     = byte_vld ? spec_calc : {CHK_W{1'b0}};
    end else if (byte_vld) begin
      if (include_now) begin
        commit_nxt   = spec_q;
        any_incl_nxt = 1'b1;
      end
      pend_nxt = 1'b1;
      spec_nxt = spec_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q   <= {CHK_W{1'b0}};
      spec_q     <= {CHK_W{1'b0}};
      pend_q     <= 1'b0;
      any_incl_q <= 1'b0;
    end else if (upd_en) begin
      commit_q   <= commit_nxt;
      spec_q     <= spec_nxt;
      pend_q     <= pend_nxt;
      any_incl_q <= any_incl_nxt;
    end
  end
endmodule

// File: rtl/rbc_good_flag.sv
module rbc_good_flag #(
  parameter int unsigned CHK_W = 16
) (
  input  logic [CHK_W-1:0] commit_q,
  input  logic             any_incl_q,
  output logic             good
);
  assign good = any_incl_q & (commit_q == {CHK_W{1'b0}});
endmodule

// File: rtl/deferred_check_rx.sv
module deferred_check_rx
  import rbc_pkg::*;
#(
  parameter int unsigned CHECK_W = CHK_W,
  parameter int unsigned DATA_W  = BYTE_W,
  parameter logic [CHECK_W-1:0] MASK = CHK_MASK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               byte_vld,
  input  logic [DATA_W-1:0]  byte_data,
  input  logic               keep,
  output logic [CHECK_W-1:0] check_value,
  output logic               block_good
);
  logic [CHECK_W-1:0] commit_nxt;
  logic [CHECK_W-1:0] commit_q;
  logic [CHECK_W-1:0] spec_calc;
  logic               any_incl_q;

  rbc_crc_step #(.CHK_W(CHECK_W), .DATA_W(DATA_W), .MASK(MASK)) u_step (
    .seed   (commit_nxt),
    .data   (byte_data),
    .result (spec_calc)
  );

  rbc_defer_core #(.CHK_W(CHECK_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .byte_vld   (byte_vld),
    .keep       (keep),
    .spec_calc  (spec_calc),
    .commit_nxt (commit_nxt),
    .commit_q   (commit_q),
    .any_incl_q (any_incl_q)
  );

  rbc_good_flag #(.CHK_W(CHECK_W)) u_good (
    .commit_q   (commit_q),
    .any_incl_q (any_incl_q),
    .good       (block_good)
  );

  assign check_value = commit_q;
endmodule

// File: rtl/deferred_check_rx_chk.sv
module deferred_check_rx_chk #(
  parameter int unsigned CHECK_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               byte_vld,
  input  logic               keep,
  input  logic [CHECK_W-1:0] check_value,
  input  logic               block_good
);
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (check_value == '0) && !block_good);

  assert_drop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !restart && !keep) |=> $stable(check_value));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !restart) |=> ($stable(check_value) && $stable(block_good)));

  assert_good_means_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_good |-> (check_value == '0));

  assert_good_needs_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_good) |-> $past(byte_vld && keep && !restart));
endmodule

bind deferred_check_rx deferred_check_rx_chk #(.CHECK_W(CHECK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .byte_vld    (byte_vld),
  .keep        (keep),
  .check_value (check_value),
  .block_good  (block_good)
);

// File: tb/deferred_check_rx_test.sv
`timescale 1ns/1ps
module deferred_check_rx_test;
  logic        clk;
  logic        rst_n;
  logic        restart;
  logic        byte_vld;
  logic [7:0]  byte_data;
  logic        keep;
  logic [15:0] check_value;
  logic        block_good;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  // behavioural reference: a held byte plus a committed integer
  int  m_commit;
  int  m_held;
  bit  m_has_held;
  bit  m_any;

  deferred_check_rx uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .byte_vld(byte_vld),
    .byte_data(byte_data), .keep(keep),
    .check_value(check_value), .block_good(block_good)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int crc_ref(input int c, input int d);
    int r = c;
    for (int i = 0; i < 8; i++) begin
      if (((r ^ (d >> i)) & 1) != 0) r = (r >> 1) ^ 32'hA001;
      else r = r >> 1;
    end
    return r & 32'hFFFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_commit = 0; m_has_held = 0; m_any = 0; m_held = 0;
    end else if (restart) begin
      m_commit = 0; m_any = 0;
      m_has_held = byte_vld;
      m_held = byte_data;
    end else if (byte_vld) begin
      if (m_has_held && keep) begin
        m_commit = crc_ref(m_commit, m_held);
        m_any = 1;
      end
      m_held = byte_data;
      m_has_held = 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R2 R4 R5 per-cycle check_value", check_value, m_commit);
      check("R8 per-cycle block_good", block_good, (m_any && m_commit == 0) ? 1 : 0);
    end
  end

  task automatic step(input bit v, input int d, input bit k, input bit rs);
    byte_vld = v; byte_data = d[7:0]; keep = k; restart = rs;
    @(negedge clk);
    byte_vld = 0; restart = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lf;
    int held;
    int exp;
    int inc_crc;
    rst_n = 0; restart = 0; byte_vld = 0; byte_data = 0; keep = 0;
    repeat (3) @(negedge clk);
    check("R1 reset check_value", check_value, 0);
    check("R1 reset block_good", block_good, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release value", check_value, 0);
    check("R1 after release good", block_good, 0);
    cmp_on = 1;

    // R3: first byte stays pending
    step(1, 8'h31, 1, 0);
    check("R3 first byte pending", check_value, 0);
    // R4: next strobe with keep=1 includes it
    step(1, 8'h32, 1, 0);
    exp = crc_ref(0, 8'h31);
    check("R4 include pending", check_value, exp);
    // R5: keep=0 drops 0x32
    step(1, 8'h33, 0, 0);
    check("R5 drop pending", check_value, exp);
    // R6: keep toggles without strobe
    for (int i = 0; i < 4; i++) step(0, 8'hFF, i[0], 0);
    check("R6 idle keep ignored", check_value, exp);
    step(1, 8'h34, 1, 0);
    exp = crc_ref(exp, 8'h33);
    check("R6 pending byte survived idle", check_value, exp);

    // R2: stream with mixed keep patterns and gaps
    lf = 32'h5A;
    for (int i = 0; i < 60; i++) begin
      lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 8'hFF;
      if (i % 7 == 3) step(0, 0, 1, 0);
      step(1, lf, (i < 20) ? 1'b1 : (i < 40 ? i[0] : 1'b0), 0);
    end
    check("R2 stream vs model", check_value, m_commit);

    // R7: restart coinciding with a strobe while a byte is held
    step(1, 8'hA5, 1, 0);
    step(1, 8'h5C, 1, 1);
    check("R7 restart clears value", check_value, 0);
    check("R7 restart clears good", block_good, 0);
    step(1, 8'h11, 1, 0);
    check("R7 strobe byte became first pending", check_value, crc_ref(0, 8'h5C));

    // R9: block with dropped control bytes, closed by its check bytes
    step(0, 0, 0, 1);
    inc_crc = 0;
    held = -1;
    for (int i = 0; i < 12; i++) begin
      int b = (i * 37 + 11) & 8'hFF;
      bit prev_ctrl = (held >= 0) && (held == 8'h10 || held == 8'h02);
      if (i == 4) b = 8'h10;
      if (i == 8) b = 8'h02;
      step(1, b, !prev_ctrl, 0);
      if (held >= 0 && !prev_ctrl) inc_crc = crc_ref(inc_crc, held);
      held = b;
    end
    inc_crc = crc_ref(inc_crc, held);
    step(1, inc_crc & 8'hFF, 1, 0);
    step(1, (inc_crc >> 8) & 8'hFF, 1, 0);
    check("R9 not good before trailer", block_good, 0);
    step(1, 8'hFF, 1, 0);
    check("R9 good after trailer", block_good, 1);
    check("R8 good with zero value", check_value, 0);
    step(1, 8'h00, 1, 0);
    check("R8 good drops on nonzero", block_good, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule